// File: doc/BRIEF.md
# Cascaded Bus Request Sub-Arbiter

This block lets three local bus masters share one request/grant pair that leads to a central arbiter further up the bus. Each local master has its own active-low request input and active-low grant output. The block merges the local requests into a single upstream request. When the upstream arbiter answers with its grant, the block passes that grant on to exactly one local master. It chooses that master by rotating priority, so the master served last drops to the back of the queue.

The block watches the bus transaction-frame and target-stop signals. It uses them to decide when a grant may be taken away from its owner and handed on. A grant is never moved away from a master whose transaction is still running. The only exception is the upstream grant being withdrawn. A target stop counts as a fairness hint: it pushes the grant on to the next master in rotation once the bus goes idle. Everything runs on the bus clock. The bus reset is asynchronous and active-low, and its release is synchronised internally. A power-down input forces every output to its inactive level.

Top module: `casc_subarb`

## Requirements
- R1: Local master i (i = 0, 1, 2) uses bit i of `mst_req_n` and `mst_gnt_n`. Both are active-low: 0 means asserted.
- R2: `up_req_n` is registered. One clock after any bit of `mst_req_n` is sampled low while `pwr_down` is 0, it is 0. Otherwise it is 1 one clock later.
- R3: Grants rotate. When master k gives up a grant, the next search starts at master (k+1) mod 3. After reset, master 0 has the highest priority.
- R4: Between the deassertion of one local grant and the assertion of a different local grant, all bits of `mst_gnt_n` are high for at least one full clock.
- R5: A local grant is asserted only in a cycle that follows a cycle in which `up_gnt_n` was sampled low. From idle, the grant appears one clock after `up_gnt_n` is sampled low while a request is pending.
- R6: If `bus_stop_n` is sampled low while a grant is held, the grant is released on the first edge where `bus_frame_n` is high. The grant then passes to the next requester in rotation, even if the owner still requests.
- R7: While reset is active, and one clock after `pwr_down` is sampled high, all bits of `mst_gnt_n` and `up_req_n` are 1.
- R8: While `bus_frame_n` is low, a dropped owner request or a seen stop does not release the grant.
- R9: If `up_gnt_n` is sampled high while a local grant is held, that grant is deasserted at the next clock edge, whatever `bus_frame_n` shows.
- R10: When the owner's request is sampled high with `bus_frame_n` high, the grant is deasserted at the next edge, and the rotation pointer moves past that master.
- R11: At most one bit of `mst_gnt_n` is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| pwr_down | input | 1 | High forces all outputs inactive |
| bus_frame_n | input | 1 | Transaction frame, low while a transaction is in its address or data phase (tie high if unused) |
| bus_stop_n | input | 1 | Target stop, low when a target stops the transaction |
| up_gnt_n | input | 1 | Grant from the upstream arbiter, active-low |
| up_req_n | output | 1 | Merged request to the upstream arbiter, active-low |
| mst_req_n | input | 3 | Local master requests, active-low, bit i for master i |
| mst_gnt_n | output | 3 | Local master grants, active-low, bit i for master i |

## Verification
The bench hands the grant from one master to another in three ways: the owner drops its request, a target stop is seen, and the upstream grant is withdrawn. In each case it checks the idle clock between owners. A design that skipped that clock would overlap or abut two grants on the bus. The bench holds the frame signal low across a dropped request and across a stop. A design that ignored the frame would pull the grant in the middle of a transaction. It also checks that the search restarts after the last owner, since a design with fixed priority would keep serving master 0. Power-down and recovery are exercised too, so a design that kept a stale grant during power-down would be caught.

// File: rtl/subarb_pkg.sv
package subarb_pkg;
  typedef enum logic {ST_IDLE, ST_OWN} own_state_t;
endpackage

// File: rtl/subarb_rr_pick.sv
module subarb_rr_pick #(
  parameter int N_MST = 3,
  parameter int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] win,
  output logic             hit
);
  // search begins one past the last owner and wraps
  always_comb begin
    int cand;
    win = '0;
    hit = 1'b0;
    cand = 0;
    for (int off = 1; off <= N_MST; off++) begin
      cand = (int'(last) + off) % N_MST;
      if (!hit && req[cand]) begin
        hit = 1'b1;
        win = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/subarb_grant_ctl.sv
module subarb_grant_ctl
  import subarb_pkg::*;
#(
  parameter int N_MST = 3,
  parameter int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             frame_act,
  input  logic             stop_act,
  input  logic             up_gnt,
  input  logic [N_MST-1:0] req,
  output logic [N_MST-1:0] gnt
);
  own_state_t       st_q, st_d;
  logic [IDX_W-1:0] owner_q, owner_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             stop_seen_q, stop_seen_d;
  logic [N_MST-1:0] gnt_q, gnt_d;
  logic [IDX_W-1:0] win;
  logic             hit;
  logic             stop_hit;
  logic             may_move;

  subarb_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
    .req (req),
    .last(last_q),
    .win (win),
    .hit (hit)
  );

  assign stop_hit = stop_seen_q | stop_act;
  assign may_move = !frame_act && (!req[owner_q] || stop_hit);

  always_comb begin
    st_d        = st_q;
    owner_d     = owner_q;
    last_d      = last_q;
    stop_seen_d = stop_seen_q;
    gnt_d       = gnt_q;
    if (pwr_down) begin
      st_d        = ST_IDLE;
      stop_seen_d = 1'b0;
      gnt_d       = '0;
    end else if (st_q == ST_IDLE) begin
      if (up_gnt && hit) begin
        st_d        = ST_OWN;
        owner_d     = win;
        stop_seen_d = 1'b0;
        gnt_d       = '0;
        gnt_d[win]  = 1'b1;
      end
    end else begin
      if (!up_gnt || may_move) begin
        st_d        = ST_IDLE;
        last_d      = owner_q;
        stop_seen_d = 1'b0;
        gnt_d       = '0;
      end else begin
        stop_seen_d = stop_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      owner_q     <= '0;
      last_q      <= IDX_W'(N_MST - 1);
      stop_seen_q <= 1'b0;
      gnt_q       <= '0;
    end else begin
      st_q        <= st_d;
      owner_q     <= owner_d;
      last_q      <= last_d;
      stop_seen_q <= stop_seen_d;
      gnt_q       <= gnt_d;
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/casc_subarb.sv
module casc_subarb #(
  parameter int N_MST    = 3,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             bus_frame_n,
  input  logic             bus_stop_n,
  input  logic             up_gnt_n,
  output logic             up_req_n,
  input  logic [N_MST-1:0] mst_req_n,
  output logic [N_MST-1:0] mst_gnt_n
);
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_s_n;
  logic                up_req_q, up_req_d;
  logic [N_MST-1:0]    gnt;

  // asynchronous assertion, synchronous release
  generate
    if (SYNC_STG == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_s_n = rst_sync_q[SYNC_STG-1];

  assign up_req_d = !pwr_down && (mst_req_n != '1);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) up_req_q <= 1'b0;
    else          up_req_q <= up_req_d;
  end

  subarb_grant_ctl #(.N_MST(N_MST), .IDX_W(IDX_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .pwr_down (pwr_down),
    .frame_act(!bus_frame_n),
    .stop_act (!bus_stop_n),
    .up_gnt   (!up_gnt_n),
    .req      (~mst_req_n),
    .gnt      (gnt)
  );

  assign up_req_n  = !up_req_q;
  assign mst_gnt_n = ~gnt;
endmodule

// File: rtl/subarb_chk.sv
module subarb_chk #(
  parameter int N_MST = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             up_gnt_n,
  input logic             up_req_n,
  input logic [N_MST-1:0] mst_req_n,
  input logic [N_MST-1:0] mst_gnt_n
);
  p_one_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mst_gnt_n) <= 1);

  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mst_gnt_n) != '1) && (mst_gnt_n != '1)) |-> (mst_gnt_n == $past(mst_gnt_n)));

  p_needs_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_gnt_n != '1) |-> !$past(up_gnt_n));

  p_up_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    up_gnt_n |=> (mst_gnt_n == '1));

  p_pdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> ((mst_gnt_n == '1) && up_req_n));

  p_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (up_req_n == ($past(pwr_down) || ($past(mst_req_n) == '1))));
endmodule

bind casc_subarb subarb_chk #(.N_MST(N_MST)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .pwr_down (pwr_down),
  .up_gnt_n (up_gnt_n),
  .up_req_n (up_req_n),
  .mst_req_n(mst_req_n),
  .mst_gnt_n(mst_gnt_n)
);

// File: tb/casc_subarb_tb.sv
`timescale 1ns/1ps
module casc_subarb_tb;
  logic       clk = 1'b0;
  logic       rst_n, pwr_down, bus_frame_n, bus_stop_n, up_gnt_n;
  logic       up_req_n;
  logic [2:0] mst_req_n, mst_gnt_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] prev_gnt = 3'b111;

  always #2 clk = ~clk;

  casc_subarb u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .bus_frame_n(bus_frame_n), .bus_stop_n(bus_stop_n),
    .up_gnt_n(up_gnt_n), .up_req_n(up_req_n),
    .mst_req_n(mst_req_n), .mst_gnt_n(mst_gnt_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [2:0] g, input logic r, input string tag);
    exp_q.push_back({g, r});
    tag_q.push_back(tag);
  endtask

  // monitor: scoreboard compare plus grant invariants
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mst_gnt_n != prev_gnt) begin
        n_chk++;
        if ($countones(~mst_gnt_n) > 1) begin
          n_bad++;
          $display("FAIL R11 gnt=%b expected at most one low", mst_gnt_n);
        end else if (prev_gnt != 3'b111 && mst_gnt_n != 3'b111) begin
          n_bad++;
          $display("FAIL R4 gnt=%b prev=%b expected idle gap", mst_gnt_n, prev_gnt);
        end
      end
      prev_gnt = mst_gnt_n;
    end
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({mst_gnt_n, up_req_n} !== e) begin
        n_bad++;
        $display("FAIL %s gnt=%b req=%b expected gnt=%b req=%b",
                 t, mst_gnt_n, up_req_n, e[3:1], e[0]);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_down = 1'b0; bus_frame_n = 1'b1; bus_stop_n = 1'b1;
    up_gnt_n = 1'b1; mst_req_n = 3'b111;
    tick(); tick();
    expect_out(3'b111, 1'b1, "R7 reset");
    rst_n = 1'b1;
    tick(); tick(); tick();
    expect_out(3'b111, 1'b1, "R2 no request");
    mst_req_n = 3'b110;
    tick(); expect_out(3'b111, 1'b0, "R2 merge, R5 no upstream grant");
    up_gnt_n = 1'b0;
    tick(); expect_out(3'b110, 1'b0, "R5 grant follows, R3 master0 first");
    tick(); expect_out(3'b110, 1'b0, "R1 grant held");
    up_gnt_n = 1'b1;
    tick(); expect_out(3'b111, 1'b0, "R9 upstream grant withdrawn");
    up_gnt_n = 1'b0;
    tick(); expect_out(3'b110, 1'b0, "R5 regrant");
    mst_req_n = 3'b000;
    tick(); expect_out(3'b110, 1'b0, "R10 owner still requesting");
    mst_req_n = 3'b001;
    tick(); expect_out(3'b111, 1'b0, "R10 release on request drop");
    tick(); expect_out(3'b101, 1'b0, "R3 next is master1, R4 gap");
    mst_req_n = 3'b010; bus_frame_n = 1'b0;
    tick(); expect_out(3'b101, 1'b0, "R8 frame holds grant");
    tick(); expect_out(3'b101, 1'b0, "R8 frame still holds");
    bus_frame_n = 1'b1;
    tick(); expect_out(3'b111, 1'b0, "R10 release after frame");
    tick(); expect_out(3'b011, 1'b0, "R3 rotation to master2");
    mst_req_n = 3'b000; bus_frame_n = 1'b0; bus_stop_n = 1'b0;
    tick(); expect_out(3'b011, 1'b0, "R8 stop during frame");
    bus_stop_n = 1'b1; bus_frame_n = 1'b1;
    tick(); expect_out(3'b111, 1'b0, "R6 release after stop");
    tick(); expect_out(3'b110, 1'b0, "R6 pass to master0");
    pwr_down = 1'b1;
    tick(); expect_out(3'b111, 1'b1, "R7 power down");
    tick(); expect_out(3'b111, 1'b1, "R7 power down held");
    pwr_down = 1'b0;
    tick(); expect_out(3'b110, 1'b0, "R7 recovery, R3 pointer kept");
    mst_req_n = 3'b111;
    tick(); expect_out(3'b111, 1'b1, "R2 all requests gone, R10");
    tick(); tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule